// File: doc/BRIEF.md
# Time-Shared Processor Bus Demultiplexer

This block connects an early 8-bit processor with a single time-shared bus to a test-harness memory. Over one machine cycle the processor places the low address byte, then the upper address bits together with a cycle type, and finally the data byte, all on the same eight wires. The block follows the processor's encoded state outputs, which are qualified by a sync strobe. It captures each piece in its own phase, rebuilds a 14-bit address and decodes the cycle type. In the data phase it either supplies a byte from an internal 4 KB program RAM or stores the byte that the processor drives.

The processor has no reset pin. It leaves power-on in the stopped state and treats both 0x00 and 0xFF as halt. To start it, the block raises an interrupt request after its own reset and holds it until the processor acknowledges it. In the acknowledge fetch, the block substitutes a restart instruction that vectors to address 0. Any fetch that would return a halt opcode is flagged. An illegal succession of processor states raises a protocol-error pulse. The bench loads the RAM through ordinary processor write cycles. The RAM is not cleared by reset, so a program survives a re-wake.

Top module: `cpu_bus_demux`

## Requirements
- R1: While reset is applied and directly after it, bus_oe_o, proto_err_o and halt_fetch_o are 0 and int_req_o is 1.
- R2: The state code on cpu_state_i is taken only in a cycle with cpu_sync_i high. The codes are 000 wait, 001 second address phase, 010 first address phase, 011 first address phase of an interrupt acknowledge, 100 data phase, 101 fifth phase, 110 stopped, 111 fourth phase. The legal successors are: first address phase (either kind) → second address phase; second address phase or wait → wait or data phase; data phase → fourth phase, stopped, or either first address phase; fourth phase → fifth phase or either first address phase; fifth phase → either first address phase; stopped → stopped or acknowledge first phase. The state assumed after reset is stopped. An illegal successor makes proto_err_o high for exactly the cycle after that sync.
- R3: At a sync in either first address phase, bus_i is captured into addr_o[7:0], which then holds until the next such sync.
- R4: At a sync in the second address phase, bus_i[5:0] is captured into addr_o[13:8] and bus_i[7:6] into cyc_type_o. The type codes are 00 instruction fetch, 01 memory read, 10 I/O, 11 memory write.
- R5: In a fetch or memory-read cycle, from the cycle after the data-phase sync until the next sync, bus_oe_o is 1 and bus_o carries the RAM byte at the latched address.
- R6: In a memory-write cycle, bus_i at the data-phase sync is stored in the RAM, and bus_oe_o stays 0.
- R7: An I/O cycle neither drives the bus nor changes the RAM.
- R8: bus_oe_o is 0 in every phase other than the data phase of a fetch or memory read, including across wait states.
- R9: The RAM holds 4096 bytes indexed by addr_o[11:0]. addr_o[13:12] are ignored, so the RAM mirrors four times.
- R10: int_req_o stays 1 from reset until the first sync in the acknowledge first phase, and stays 0 after that until the next reset.
- R11: In a fetch cycle started by the acknowledge first phase while int_req_o was 1, the data phase drives 0x05 (restart to 0) whatever the RAM holds.
- R12: halt_fetch_o is 1 exactly while the block drives a fetched RAM byte equal to 0x00 or 0xFF.
- R13: The substituted restart byte never raises halt_fetch_o, even when the RAM at that address holds a halt opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the processor's state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_state_i | input | 3 | Encoded processor state |
| cpu_sync_i | input | 1 | One-cycle strobe marking a new valid state |
| bus_i | input | 8 | Value seen on the time-shared bus |
| bus_o | output | 8 | Byte driven towards the processor |
| bus_oe_o | output | 1 | Output enable for bus_o; 0 means tri-stated |
| int_req_o | output | 1 | Wake-up interrupt request |
| addr_o | output | 14 | Rebuilt address |
| cyc_type_o | output | 2 | Decoded cycle type |
| halt_fetch_o | output | 1 | A halt opcode is being fetched |
| proto_err_o | output | 1 | Illegal state succession seen |

## Verification
Restart substitution and halt detection can fall in the same data phase. This happens when the wake-up fetch targets address 0 and that location already holds 0x00. The bench first stores 0x00 at address 0 through normal write cycles. It then resets the block, which leaves the RAM intact, and replays the wake-up. It judges the data phase by requiring 0x05 on the bus with the halt flag low. A behavioural reference model, updated at every sync, also compares all outputs on every clock.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

   typedef enum logic [2:0] {
      ST_WAIT = 3'b000,
      ST_T2   = 3'b001,
      ST_T1   = 3'b010,
      ST_T1I  = 3'b011,
      ST_T3   = 3'b100,
      ST_T5   = 3'b101,
      ST_STOP = 3'b110,
      ST_T4   = 3'b111
   } cpu_st_e;

   typedef enum logic [1:0] {
      CY_FETCH  = 2'b00,
      CY_MREAD  = 2'b01,
      CY_IO     = 2'b10,
      CY_MWRITE = 2'b11
   } cyc_e;

   // successor rule of the processor state machine
   function automatic logic step_ok(cpu_st_e from, cpu_st_e to);
      logic ok;
      case (from)
         ST_T1, ST_T1I: ok = (to == ST_T2);
         ST_T2, ST_WAIT: ok = (to == ST_WAIT) || (to == ST_T3);
         ST_T3: ok = (to == ST_T4) || (to == ST_STOP) ||
                     (to == ST_T1) || (to == ST_T1I);
         ST_T4: ok = (to == ST_T5) || (to == ST_T1) || (to == ST_T1I);
         ST_T5: ok = (to == ST_T1) || (to == ST_T1I);
         ST_STOP: ok = (to == ST_STOP) || (to == ST_T1I);
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/bdm_phase_trk.sv
module bdm_phase_trk
   import bdm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sync_i,
   input  cpu_st_e st_i,
   output cpu_st_e cur_o,
   output logic    stb_lo_o,
   output logic    stb_ack_o,
   output logic    stb_hi_o,
   output logic    stb_data_o,
   output logic    perr_o
);

   cpu_st_e cur_q;
   logic    perr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= ST_STOP;
         perr_q <= 1'b0;
      end else begin
         perr_q <= sync_i && !step_ok(cur_q, st_i);
         if (sync_i) cur_q <= st_i;
      end
   end

   assign cur_o      = cur_q;
   assign perr_o     = perr_q;
   assign stb_lo_o   = sync_i && ((st_i == ST_T1) || (st_i == ST_T1I));
   assign stb_ack_o  = sync_i && (st_i == ST_T1I);
   assign stb_hi_o   = sync_i && (st_i == ST_T2);
   assign stb_data_o = sync_i && (st_i == ST_T3);

   p_perr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> !perr_o);
   p_perr_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i && (cur_o == ST_T2) && (st_i == ST_T1) |=> perr_o);

endmodule

// File: rtl/bdm_addr_cap.sv
module bdm_addr_cap
   import bdm_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_lo_i,
   input  logic              stb_hi_i,
   input  logic [7:0]        bus_i,
   output logic [ADDR_W-1:0] addr_o,
   output cyc_e              type_o
);

   localparam int LO_W = 8;
   localparam int HI_W = ADDR_W - LO_W;

   if (HI_W < 1 || HI_W > 6) begin : g_bad_width
      $error("bdm_addr_cap: ADDR_W must lie between 9 and 14");
   end

   logic [LO_W-1:0] lo_q;
   logic [HI_W-1:0] hi_q;
   cyc_e            ty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         ty_q <= CY_FETCH;
      end else begin
         if (stb_lo_i) lo_q <= bus_i;
         if (stb_hi_i) begin
            hi_q <= bus_i[HI_W-1:0];
            ty_q <= cyc_e'(bus_i[7:6]);
         end
      end
   end

   assign addr_o = {hi_q, lo_q};
   assign type_o = ty_q;

   p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_lo_i |=> $stable(addr_o[LO_W-1:0]));
   p_hi_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stb_hi_i |=> (addr_o[ADDR_W-1:LO_W] == $past(bus_i[HI_W-1:0])) &&
                   (type_o == cyc_e'($past(bus_i[7:6]))));

endmodule

// File: rtl/bdm_wake_ctl.sv
module bdm_wake_ctl #(
   parameter bit WAKE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_lo_i,
   input  logic stb_ack_i,
   output logic irq_o,
   output logic jam_o
);

   if (WAKE_EN) begin : g_wake
      logic irq_q, jam_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b1;
            jam_q <= 1'b0;
         end else begin
            if (stb_lo_i)  jam_q <= stb_ack_i && irq_q;
            if (stb_ack_i) irq_q <= 1'b0;
         end
      end
      assign irq_o = irq_q;
      assign jam_o = jam_q;

      p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o && !stb_ack_i |=> irq_o);
      p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_o |=> !irq_o);
   end else begin : g_no_wake
      logic unused_wake;
      assign unused_wake = stb_lo_i ^ stb_ack_i;
      assign irq_o = 1'b0;
      assign jam_o = 1'b0;
   end

endmodule

// File: rtl/bdm_prog_ram.sv
module bdm_prog_ram #(
   parameter int ADDR_W = 14,
   parameter int MEM_AW = 12
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [7:0]        wdata_i,
   input  logic              re_i,
   output logic [7:0]        rdata_o
);

   localparam int DEPTH = 1 << MEM_AW;

   if (MEM_AW < 1 || MEM_AW > ADDR_W) begin : g_bad_depth
      $error("bdm_prog_ram: MEM_AW must lie between 1 and ADDR_W");
   end

   logic [MEM_AW-1:0] idx;
   assign idx = addr_i[MEM_AW-1:0];

   // upper address bits are dropped so the array repeats through the space
   if (MEM_AW < ADDR_W) begin : g_mirror
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:MEM_AW];
   end

   logic [7:0] mem_q [DEPTH];
   logic [7:0] rd_q;

   always_ff @(posedge clk) begin
      if (we_i) mem_q[idx] <= wdata_i;
      if (re_i) rd_q <= mem_q[idx];
   end

   assign rdata_o = rd_q;

endmodule

// File: rtl/cpu_bus_demux.sv
module cpu_bus_demux
   import bdm_pkg::*;
#(
   parameter int         ADDR_W     = 14,
   parameter int         MEM_AW     = 12,
   parameter logic [7:0] RESTART_OP = 8'h05,
   parameter bit         WAKE_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cpu_state_i,
   input  logic              cpu_sync_i,
   input  logic [7:0]        bus_i,
   output logic [7:0]        bus_o,
   output logic              bus_oe_o,
   output logic              int_req_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        cyc_type_o,
   output logic              halt_fetch_o,
   output logic              proto_err_o
);

   cpu_st_e cur_st;
   cyc_e    cyc;
   logic    stb_lo, stb_ack, stb_hi, stb_data;
   logic    jam;
   logic    ram_we;
   logic [7:0] ram_rd;
   logic    drive_q, jam_hit_q;

   bdm_phase_trk u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (cpu_sync_i),
      .st_i       (cpu_st_e'(cpu_state_i)),
      .cur_o      (cur_st),
      .stb_lo_o   (stb_lo),
      .stb_ack_o  (stb_ack),
      .stb_hi_o   (stb_hi),
      .stb_data_o (stb_data),
      .perr_o     (proto_err_o)
   );

   bdm_addr_cap #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_lo_i (stb_lo),
      .stb_hi_i (stb_hi),
      .bus_i    (bus_i),
      .addr_o   (addr_o),
      .type_o   (cyc)
   );

   bdm_wake_ctl #(.WAKE_EN(WAKE_EN)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_lo_i  (stb_lo),
      .stb_ack_i (stb_ack),
      .irq_o     (int_req_o),
      .jam_o     (jam)
   );

   assign ram_we = stb_data && (cyc == CY_MWRITE);

   bdm_prog_ram #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_ram (
      .clk     (clk),
      .addr_i  (addr_o),
      .we_i    (ram_we),
      .wdata_i (bus_i),
      .re_i    (stb_data),
      .rdata_o (ram_rd)
   );

   // data-phase drive window: opened by the data-phase sync, closed by any other
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q   <= 1'b0;
         jam_hit_q <= 1'b0;
      end else if (cpu_sync_i) begin
         drive_q   <= stb_data && ((cyc == CY_FETCH) || (cyc == CY_MREAD));
         jam_hit_q <= stb_data && jam && (cyc == CY_FETCH);
      end
   end

   assign bus_oe_o     = drive_q;
   assign bus_o        = jam_hit_q ? RESTART_OP : ram_rd;
   assign cyc_type_o   = cyc;
   assign halt_fetch_o = drive_q && !jam_hit_q && (cyc == CY_FETCH) &&
                         ((ram_rd == 8'h00) || (ram_rd == 8'hFF));

   p_oe_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (cur_st == ST_T3));
   p_oe_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (cyc == CY_FETCH) || (cyc == CY_MREAD));
   p_jam_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      jam |-> !int_req_o);
   p_no_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !bus_oe_o);

endmodule

// File: tb/cpu_bus_demux_test.sv
`timescale 1ns/1ps
module cpu_bus_demux_test;

   localparam logic [2:0] S_WAIT = 3'd0, S_T2 = 3'd1, S_T1 = 3'd2, S_T1I = 3'd3,
                          S_T3 = 3'd4, S_T5 = 3'd5, S_STOP = 3'd6, S_T4 = 3'd7;
   localparam int TY_F = 0, TY_R = 1, TY_IO = 2, TY_W = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  state_i = S_STOP;
   logic        sync_i = 1'b0;
   logic [7:0]  bus_i = 8'h00;
   logic [7:0]  bus_o;
   logic        bus_oe;
   logic        irq;
   logic [13:0] addr;
   logic [1:0]  cty;
   logic        halt;
   logic        perr;

   cpu_bus_demux uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_state_i  (state_i),
      .cpu_sync_i   (sync_i),
      .bus_i        (bus_i),
      .bus_o        (bus_o),
      .bus_oe_o     (bus_oe),
      .int_req_o    (irq),
      .addr_o       (addr),
      .cyc_type_o   (cty),
      .halt_fetch_o (halt),
      .proto_err_o  (perr)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit running = 0;
   bit done = 0;

   // reference model
   int         m_prev;
   bit         e_irq, e_perr, e_oe, e_known, e_jamdrv, m_jam;
   logic [7:0] e_data, m_lo;
   logic [5:0] m_hi;
   int         m_ty;
   logic [7:0] mdl_mem [4096];
   bit         known [4096];

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit legal(int p, int n);
      case (p)
         S_T1, S_T1I: return n == S_T2;
         S_T2, S_WAIT: return n == S_WAIT || n == S_T3;
         S_T3: return n == S_T4 || n == S_STOP || n == S_T1 || n == S_T1I;
         S_T4: return n == S_T5 || n == S_T1 || n == S_T1I;
         S_T5: return n == S_T1 || n == S_T1I;
         default: return n == S_STOP || n == S_T1I;
      endcase
   endfunction

   function automatic bit exp_halt();
      return e_oe && e_known && !e_jamdrv && m_ty == TY_F &&
             (e_data == 8'h00 || e_data == 8'hFF);
   endfunction

   task automatic model_reset();
      m_prev = S_STOP; e_irq = 1; e_perr = 0; e_oe = 0; e_known = 0;
      e_jamdrv = 0; m_jam = 0; e_data = 0; m_lo = 0; m_hi = 0; m_ty = 0;
   endtask

   task automatic model_apply(logic [2:0] s, logic [7:0] b);
      int idx;
      e_perr = !legal(m_prev, s);
      m_prev = s;
      e_oe = 0; e_jamdrv = 0;
      if (s == S_T1 || s == S_T1I) begin
         m_lo = b;
         m_jam = (s == S_T1I) && e_irq;
         if (s == S_T1I) e_irq = 0;
      end
      if (s == S_T2) begin
         m_hi = b[5:0];
         m_ty = int'(b[7:6]);
      end
      if (s == S_T3) begin
         idx = int'({m_hi[3:0], m_lo});
         if (m_ty == TY_F && m_jam) begin
            e_oe = 1; e_jamdrv = 1; e_data = 8'h05; e_known = 1;
         end else if (m_ty == TY_F || m_ty == TY_R) begin
            e_oe = 1; e_data = mdl_mem[idx]; e_known = known[idx];
         end
         if (m_ty == TY_W) begin
            mdl_mem[idx] = b;
            known[idx] = 1;
         end
      end
   endtask

   // every-clock comparison against the model
   always @(posedge clk) begin
      #2;
      if (running && rst_n) begin
         check("R8 bus_oe", int'(bus_oe), int'(e_oe));
         if (e_oe && e_known) check("R5 bus_o", int'(bus_o), int'(e_data));
         check("R3 addr_lo", int'(addr[7:0]), int'(m_lo));
         check("R4 addr_hi/type", int'({cty, addr[13:8]}), int'({m_ty[1:0], m_hi}));
         check("R10 int_req", int'(irq), int'(e_irq));
         if (!e_oe || e_known) check("R12 halt", int'(halt), int'(exp_halt()));
         check("R2 proto_err", int'(perr), int'(e_perr));
      end
   end

   task automatic step(logic [2:0] s, logic [7:0] b);
      @(negedge clk);
      state_i = s; sync_i = 1'b1; bus_i = b;
      @(posedge clk);
      model_apply(s, b);
      @(negedge clk);
      sync_i = 1'b0;
      @(posedge clk);
      e_perr = 0;
   endtask

   // ending: 0 full cycle, 1 stop after data phase, 2 stop after fourth phase
   task automatic mcycle(int ty, logic [13:0] a, logic [7:0] d, int waits, bit ack,
                         int ending, string tag, int x_oe, int x_byte, int x_halt);
      step(ack ? S_T1I : S_T1, a[7:0]);
      step(S_T2, {ty[1:0], a[13:8]});
      for (int i = 0; i < waits; i++) step(S_WAIT, 8'h00);
      step(S_T3, d);
      #1;
      check(tag, int'(bus_oe), x_oe);
      if (x_byte >= 0) check(tag, int'(bus_o), x_byte);
      if (x_halt >= 0) check(tag, int'(halt), x_halt);
      if (ending != 1) step(S_T4, 8'h00);
      if (ending == 0) step(S_T5, 8'h00);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 reset outputs", int'({bus_oe, irq, perr, halt}), 4'b0100);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) known[i] = 0;
      model_reset();
      repeat (3) @(negedge clk);
      running = 1;
      do_reset();
      step(S_STOP, 8'h00);
      step(S_STOP, 8'h00);
      // R11 wake-up acknowledge fetch receives the restart byte
      mcycle(TY_F, 14'h0000, 8'h00, 0, 1, 0, "R11 restart jam", 1, 8'h05, 0);
      // R6 loading through write cycles
      mcycle(TY_W, 14'h0000, 8'h00, 0, 0, 0, "R6 write oe", 0, -1, -1);
      mcycle(TY_W, 14'h0001, 8'hFF, 0, 0, 0, "R6 write oe", 0, -1, -1);
      mcycle(TY_W, 14'h0002, 8'h42, 1, 0, 0, "R6 write oe", 0, -1, -1);
      mcycle(TY_W, 14'h3ABC, 8'h5A, 0, 0, 1, "R9 mirror write", 0, -1, -1);
      mcycle(TY_W, 14'h0123, 8'h11, 2, 0, 2, "R6 write waits", 0, -1, -1);
      mcycle(TY_W, 14'h0FFF, 8'hC3, 0, 0, 0, "R6 write top", 0, -1, -1);
      // R12 halt opcodes flagged, ordinary byte not
      mcycle(TY_F, 14'h0000, 8'h00, 0, 0, 0, "R12 fetch 00", 1, 8'h00, 1);
      mcycle(TY_F, 14'h0001, 8'h00, 3, 0, 0, "R12 fetch FF", 1, 8'hFF, 1);
      mcycle(TY_F, 14'h0002, 8'h00, 0, 0, 1, "R12 fetch 42", 1, 8'h42, 0);
      mcycle(TY_R, 14'h0001, 8'h00, 0, 0, 0, "R12 read FF no flag", 1, 8'hFF, 0);
      // R9 mirrored reads
      mcycle(TY_R, 14'h0ABC, 8'h00, 0, 0, 0, "R9 mirror read", 1, 8'h5A, 0);
      mcycle(TY_R, 14'h1ABC, 8'h00, 1, 0, 2, "R9 mirror read", 1, 8'h5A, 0);
      mcycle(TY_R, 14'h0123, 8'h00, 0, 0, 0, "R6 read back", 1, 8'h11, 0);
      mcycle(TY_R, 14'h0FFF, 8'h00, 0, 0, 0, "R6 read back top", 1, 8'hC3, 0);
      // R7 I/O cycle leaves the bus and the RAM alone
      mcycle(TY_IO, 14'h0123, 8'h99, 0, 0, 0, "R7 io no drive", 0, -1, -1);
      mcycle(TY_R, 14'h0123, 8'h00, 0, 0, 0, "R7 ram unchanged", 1, 8'h11, 0);
      // halt, then restart without a pending request: no substitution
      mcycle(TY_F, 14'h0000, 8'h00, 0, 0, 1, "R12 halt fetch", 1, 8'h00, 1);
      step(S_STOP, 8'h00);
      step(S_STOP, 8'h00);
      mcycle(TY_F, 14'h0002, 8'h00, 0, 1, 0, "R10 no second jam", 1, 8'h42, 0);
      // R2 illegal successions
      step(S_T1, 8'h10);
      step(S_T3, 8'h00);
      step(S_T4, 8'h00);
      step(S_T5, 8'h00);
      step(S_STOP, 8'h00);
      step(S_T1I, 8'h20);
      step(S_T1, 8'h21);
      step(S_T2, 8'h00);
      step(S_T1, 8'h22);
      step(S_T2, 8'h00);
      step(S_T3, 8'h00);
      step(S_T5, 8'h00);
      // R13 re-wake while address 0 holds a halt opcode
      do_reset();
      step(S_STOP, 8'h00);
      mcycle(TY_F, 14'h0000, 8'h00, 0, 1, 0, "R13 jam beats halt", 1, 8'h05, 0);
      mcycle(TY_F, 14'h0000, 8'h00, 0, 0, 0, "R12 after wake", 1, 8'h00, 1);
      repeat (4) @(posedge clk);
      #1;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired (R1..R13 incomplete) actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule